// File: doc/BRIEF.md
# Configurable Dual-Port Pin Controller

This block holds the per-pin configuration of a sixteen-pin I/O expander and turns it into pad controls. The pins form two ports of eight. Any pin can be handed to an LED current driver or kept as a general-purpose pin. A general-purpose pin is an input or an output. Outputs on port 0 can be driven open-drain or push-pull; port 1 always drives push-pull. Each pin gets an output enable, an output value and an LED flag, which the pad and the current-sink logic outside this block consume.

A small synchronous register interface (write strobe, address, data, and a combinational read port) sets the level, direction, mode and drive-style bits. A synchronous active-low reset returns every register to its default. While reset is held, the output levels are loaded from two strap inputs, so the value present in the last reset cycle is the one kept until the next reset.

Top module: `io_port_ctrl`

## Requirements
- R1: After reset every pin is a general-purpose output (mode and direction registers read 0), and the drive-style register reads 0, which puts port 0 in open-drain style.
- R2: After reset the level registers of both ports read all ones when both straps are 1, and all zeros for any other strap pair.
- R3: Strap changes after reset release change neither the level registers nor the pins.
- R4: Register addresses: 0 port 0 level, 1 port 1 level, 2 port 0 direction, 3 port 1 direction (bit 1 = input), 4 port 0 mode, 5 port 1 mode (bit 1 = LED), 6 drive style (bit 0 = 1 makes port 0 push-pull; other bits read 0). A written value reads back from its address after the write edge; bit n of a port register controls pin n of port 0 or pin 8+n of port 1.
- R5: A write to address 7 changes no register and no pin, and address 7 reads 0.
- R6: A pin in LED mode has its LED flag set, its output enable clear and its output value 0, whatever its direction and level bits.
- R7: A general-purpose input pin has output enable, output value and LED flag all 0.
- R8: A port 1 output pin is always push-pull: output enable 1 and output value equal to its level bit.
- R9: A port 0 output pin in open-drain style with level 0 has output enable 1 and value 0; with level 1 it has output enable 0 and value 0.
- R10: A port 0 output pin in push-pull style has output enable 1 and value equal to its level bit.
- R11: Reset takes priority over a write presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_a1 | input | 1 | Upper address-select strap |
| strap_a0 | input | 1 | Lower address-select strap |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational from the registers |
| pin_oe | output | 16 | Output enable per pin (port 0 in bits 7:0) |
| pin_out | output | 16 | Output value per pin |
| pin_led | output | 16 | LED-mode flag per pin |

## Verification
The reset load and a register write can land on the same clock edge; the bench asserts reset while a write of all ones to a mode register is still on the bus and then expects the mode register and the pins to show reset values, not the written ones. A second overlap is a read and a write of one address in one cycle: the read before the edge must show the old value and the read after it the new one. Both are judged against a bench model updated only from the requirements.

// File: rtl/io_cfg_pkg.sv
package io_cfg_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_LVL0  = 3'd0,
        RA_LVL1  = 3'd1,
        RA_DIR0  = 3'd2,
        RA_DIR1  = 3'd3,
        RA_MODE0 = 3'd4,
        RA_MODE1 = 3'd5,
        RA_STYLE = 3'd6,
        RA_NONE  = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic led;     // pin handed to LED driver
        logic is_in;   // general-purpose input
        logic level;   // requested output level
        logic od;      // open-drain style active
    } pin_cfg_t;

    typedef struct packed {
        logic oe;
        logic val;
        logic led;
    } pin_drv_t;

    function automatic pin_drv_t resolve_pin(pin_cfg_t c);
        pin_drv_t d;
        d = '0;
        if (c.led) begin
            d.led = 1'b1;
        end else if (!c.is_in) begin
            if (c.od) begin
                d.oe  = ~c.level;
                d.val = 1'b0;
            end else begin
                d.oe  = 1'b1;
                d.val = c.level;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/cfg_regs.sv
module cfg_regs
    import io_cfg_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strap_a1,
    input  logic                strap_a0,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [PORT_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [PORT_W-1:0]   rd_data,
    output logic [2*PORT_W-1:0] lvl,
    output logic [2*PORT_W-1:0] dir,
    output logic [2*PORT_W-1:0] mode,
    output logic                pp0
);
    localparam int NPINS = 2 * PORT_W;

    logic [1:0][PORT_W-1:0] lvl_q, dir_q, mode_q;
    logic                   pp0_q;
    logic                   strap_hi;

    assign strap_hi = strap_a1 & strap_a0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= {NPINS{strap_hi}};
            dir_q  <= '0;
            mode_q <= '0;
            pp0_q  <= 1'b0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                RA_LVL0:  lvl_q[0]  <= wr_data;
                RA_LVL1:  lvl_q[1]  <= wr_data;
                RA_DIR0:  dir_q[0]  <= wr_data;
                RA_DIR1:  dir_q[1]  <= wr_data;
                RA_MODE0: mode_q[0] <= wr_data;
                RA_MODE1: mode_q[1] <= wr_data;
                RA_STYLE: pp0_q     <= wr_data[0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        case (reg_addr_e'(rd_addr))
            RA_LVL0:  rd_data = lvl_q[0];
            RA_LVL1:  rd_data = lvl_q[1];
            RA_DIR0:  rd_data = dir_q[0];
            RA_DIR1:  rd_data = dir_q[1];
            RA_MODE0: rd_data = mode_q[0];
            RA_MODE1: rd_data = mode_q[1];
            RA_STYLE: rd_data[0] = pp0_q;
            default:  rd_data = '0;
        endcase
    end

    assign lvl  = lvl_q;
    assign dir  = dir_q;
    assign mode = mode_q;
    assign pp0  = pp0_q;

    // R3: without a write, the levels never move (straps ignored)
    a_r3_levels_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && rst_n) |=> $stable(lvl_q));

    // R5: a write to the unmapped address leaves all state untouched
    a_r5_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RA_NONE) |=>
            ($stable(lvl_q) && $stable(dir_q) && $stable(mode_q) && $stable(pp0_q)));

endmodule

// File: rtl/pin_drive_cell.sv
module pin_drive_cell
    import io_cfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pin_cfg_t cfg,
    output logic     oe,
    output logic     val,
    output logic     led
);
    pin_drv_t drv;

    assign drv = resolve_pin(cfg);
    assign oe  = drv.oe;
    assign val = drv.val;
    assign led = drv.led;

    // R6: LED pins never drive the pad
    a_r6_led_released: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.led |-> (led && !oe && !val));

    // R7: input pins never drive the pad
    a_r7_input_released: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.led && cfg.is_in) |-> (!oe && !led));

    // R9: open-drain never drives high
    a_r9_od_no_high: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.od |-> !(oe && val));

endmodule

// File: rtl/io_port_ctrl.sv
module io_port_ctrl
    import io_cfg_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strap_a1,
    input  logic                strap_a0,
    input  logic                wr_en,
    input  logic [2:0]          wr_addr,
    input  logic [PORT_W-1:0]   wr_data,
    input  logic [2:0]          rd_addr,
    output logic [PORT_W-1:0]   rd_data,
    output logic [2*PORT_W-1:0] pin_oe,
    output logic [2*PORT_W-1:0] pin_out,
    output logic [2*PORT_W-1:0] pin_led
);
    localparam int NPORTS = 2;
    localparam int NPINS  = NPORTS * PORT_W;

    logic [NPINS-1:0] lvl, dir, mode;
    logic             pp0;

    cfg_regs #(.PORT_W(PORT_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_a1 (strap_a1),
        .strap_a0 (strap_a0),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .lvl      (lvl),
        .dir      (dir),
        .mode     (mode),
        .pp0      (pp0)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        for (genvar b = 0; b < PORT_W; b++) begin : g_pin
            localparam int IDX = p * PORT_W + b;
            pin_cfg_t cfg;
            always_comb begin
                cfg.led   = mode[IDX];
                cfg.is_in = dir[IDX];
                cfg.level = lvl[IDX];
                if (p == 0) begin
                    cfg.od = ~pp0;
                end else begin
                    cfg.od = 1'b0;
                end
            end
            pin_drive_cell cell_i (
                .clk   (clk),
                .rst_n (rst_n),
                .cfg   (cfg),
                .oe    (pin_oe[IDX]),
                .val   (pin_out[IDX]),
                .led   (pin_led[IDX])
            );
        end
    end

endmodule

// File: tb/io_port_ctrl_tb.sv
module io_port_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_a1 = 1'b0, strap_a0 = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic [15:0] pin_oe, pin_out, pin_led;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [15:0] m_lvl, m_dir, m_mode;
    logic        m_pp0;

    always #5 clk = ~clk;

    io_port_ctrl #(.PORT_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .strap_a1(strap_a1), .strap_a0(strap_a0),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .pin_oe(pin_oe), .pin_out(pin_out), .pin_led(pin_led)
    );

    function automatic logic [47:0] exp_pins();
        logic [15:0] oe, val, led;
        oe = '0; val = '0; led = '0;
        for (int i = 0; i < 16; i++) begin
            if (m_mode[i]) led[i] = 1'b1;
            else if (m_dir[i]) ;
            else if (i < 8 && !m_pp0) oe[i] = ~m_lvl[i];
            else begin oe[i] = 1'b1; val[i] = m_lvl[i]; end
        end
        return {oe, val, led};
    endfunction

    function automatic logic [7:0] exp_read(logic [2:0] a);
        case (a)
            3'd0: return m_lvl[7:0];
            3'd1: return m_lvl[15:8];
            3'd2: return m_dir[7:0];
            3'd3: return m_dir[15:8];
            3'd4: return m_mode[7:0];
            3'd5: return m_mode[15:8];
            3'd6: return {7'b0, m_pp0};
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_write(logic [2:0] a, logic [7:0] d);
        case (a)
            3'd0: m_lvl[7:0]   = d;
            3'd1: m_lvl[15:8]  = d;
            3'd2: m_dir[7:0]   = d;
            3'd3: m_dir[15:8]  = d;
            3'd4: m_mode[7:0]  = d;
            3'd5: m_mode[15:8] = d;
            3'd6: m_pp0        = d[0];
            default: ;
        endcase
    endtask

    task automatic model_reset();
        m_lvl  = {16{strap_a1 & strap_a0}};
        m_dir  = '0;
        m_mode = '0;
        m_pp0  = 1'b0;
    endtask

    task automatic cmp(string tag, logic [47:0] act, logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_pins(string tag);
        cmp(tag, {pin_oe, pin_out, pin_led}, exp_pins());
    endtask

    task automatic chk_read(string tag, logic [2:0] a);
        rd_addr = a;
        #1;
        cmp(tag, {40'b0, rd_data}, {40'b0, exp_read(a)});
    endtask

    task automatic chk_all_regs(string tag);
        for (int a = 0; a < 8; a++) chk_read(tag, a[2:0]);
    endtask

    // drive at negedge, register at posedge, observe at next negedge
    task automatic do_write(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic do_reset(logic s1, logic s0);
        @(negedge clk);
        rst_n = 1'b0; strap_a1 = s1; strap_a0 = s0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        model_reset();

        // R1 R2: reset with straps 00
        do_reset(1'b0, 1'b0);
        chk_all_regs("R1 reset regs, straps 00");
        chk_pins("R2 pins after reset, straps 00");

        // R2: straps 11 -> levels high, port 0 released (open-drain)
        do_reset(1'b1, 1'b1);
        chk_read("R2 level p0 straps 11", 3'd0);
        chk_read("R2 level p1 straps 11", 3'd1);
        chk_pins("R1 R9 pins after reset, straps 11");
        // R2: straps 10 and 01 -> low
        do_reset(1'b1, 1'b0);
        chk_read("R2 level straps 10", 3'd1);
        do_reset(1'b0, 1'b1);
        chk_read("R2 level straps 01", 3'd0);

        // R3: straps change after release
        do_reset(1'b1, 1'b1);
        strap_a1 = 1'b0; strap_a0 = 1'b0;
        repeat (4) @(negedge clk);
        chk_read("R3 level p0 held", 3'd0);
        chk_read("R3 level p1 held", 3'd1);
        chk_pins("R3 pins held");

        // R4: read/write same address in one cycle
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd3; wr_data = 8'hA5; rd_addr = 3'd3;
        #1 cmp("R4 read before write edge", {40'b0, rd_data}, {40'b0, exp_read(3'd3)});
        @(negedge clk);
        wr_en = 1'b0; model_write(3'd3, 8'hA5);
        chk_read("R4 read after write edge", 3'd3);
        chk_pins("R7 p1 inputs");

        // R5: unmapped address
        do_write(3'd7, 8'hFF);
        chk_all_regs("R5 unmapped write ignored");
        chk_pins("R5 pins unchanged");

        // R6: LED mode overrides everything
        do_write(3'd2, 8'h0F);
        do_write(3'd0, 8'h33);
        do_write(3'd4, 8'hFF);
        do_write(3'd5, 8'hF0);
        chk_pins("R6 LED mode pins");

        // R7 R8: inputs and port 1 push-pull
        do_write(3'd4, 8'h00);
        do_write(3'd5, 8'h00);
        do_write(3'd3, 8'h00);
        do_write(3'd1, 8'h5A);
        chk_pins("R7 R8 inputs and port 1 outputs");

        // R9: port 0 open-drain
        do_write(3'd2, 8'h00);
        do_write(3'd0, 8'hC3);
        chk_pins("R9 port 0 open-drain");

        // R10: port 0 push-pull
        do_write(3'd6, 8'hFF);
        chk_read("R4 style reg reads bit0 only", 3'd6);
        chk_pins("R10 port 0 push-pull");

        // R11: reset beats a write in the same cycle
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b1; wr_addr = 3'd4; wr_data = 8'hFF;
        @(negedge clk);
        wr_en = 1'b0; rst_n = 1'b1;
        model_reset();
        chk_read("R11 mode after reset+write", 3'd4);
        chk_pins("R11 pins after reset+write");

        // random mix
        for (int k = 0; k < 300; k++) begin
            logic [2:0] a;
            logic [7:0] d;
            a = 3'($urandom_range(0, 7));
            d = 8'($urandom);
            do_write(a, d);
            chk_pins("R6 R7 R8 R9 R10 random pins");
            chk_read("R4 R5 random read", 3'($urandom_range(0, 7)));
            if (k % 50 == 49) begin
                strap_a1 = 1'($urandom); strap_a0 = 1'($urandom);
                @(negedge clk);
                chk_pins("R3 random strap change");
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule